// File: doc/BRIEF.md
# Serial Memory Command Front-End

This block is the serial side of an 8K x 8 byte-addressed non-volatile store. It acts as an SPI mode 0 target. It reads an 8-bit opcode, takes a 16-bit address when the opcode needs one, and then does one of three things:
- streams array bytes or the status byte out on the data-out line;
- hands incoming write bytes to a separate page-programming engine;
- turns the one-byte opcodes into single-cycle command pulses.

The array sits behind a simple synchronous read port, and its data returns one cycle after the request. The page engine owns everything after the handoff: the write-enable latch, block protection, programming time and the busy indication.

All four serial inputs come from another clock domain. Each one passes through a two-flop synchronizer. The serial clock edges are then detected in the system clock. Each half-period of the serial clock must therefore last at least four system clocks.

A pause input freezes a frame at any bit boundary and releases it again. While the engine reports busy, every opcode except the status read is refused.

Top module: `spi_mem_front`

## Requirements
- R1: After reset the data-out enable (`spi_miso_oe`) is low and no pulse output (`arr_rd_en`, `wr_byte_valid`, `stat_wr_valid`, `wr_commit`, `cmd_wren`, `cmd_wrdi`) has fired.
- R2: The input line is sampled on serial clock rising edges, most significant bit first. Output bits change after falling edges, most significant bit first. `spi_miso_oe` is high only during an output phase while chip select is low, and goes low once chip select rises.
- R3: Opcode 0x03 is followed by two address bytes, high byte first. Only the low 13 bits select the location and the top 3 are ignored. The addressed byte's bit 7 appears after the falling edge that follows the 24th rising edge.
- R4: A read keeps going past the first byte, each further byte coming from the next address. The address wraps from 0x1FFF to 0x0000.
- R5: Opcode 0x05 returns `status_byte` and repeats it for every further byte of the frame.
- R6: Opcode 0x02 plus an address forwards each complete data byte on `wr_byte_*` with its address. The low 6 address bits count up and wrap within the 64-byte page while the upper bits hold. `wr_commit` pulses when chip select rises if at least one whole byte arrived and the frame ended on a byte boundary.
- R7: Opcode 0x01 forwards its first data byte once on `stat_wr_*`, and any later bytes are ignored. `wr_commit` pulses at chip select rise.
- R8: Opcode 0x06 pulses `cmd_wren` and opcode 0x04 pulses `cmd_wrdi`, each when chip select rises at the end of the frame.
- R9: If `write_busy` is high when the 8th opcode bit is taken, any opcode other than 0x05 is refused: no output drive and no pulse until chip select rises.
- R10: Any opcode outside the six listed makes the rest of the frame ignored until chip select rises.
- R11: Taking `spi_hold_n` low while the serial clock is low pauses the frame. During the pause `spi_miso_oe` is low and serial clock edges and input bits are ignored. Releasing it while the serial clock is low resumes from the same bit.
- R12: Raising chip select mid-byte drops the partial byte and suppresses the commit. The next frame starts its opcode only after a chip select falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low, asynchronous |
| spi_sck | input | 1 | Serial clock, idle low, asynchronous |
| spi_mosi | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Drive enable for the data-out pad |
| write_busy | input | 1 | Page engine is in an internal write cycle |
| status_byte | input | 8 | Status value returned by opcode 0x05 |
| arr_rd_en | output | 1 | Array read request, one cycle |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | 8 | Array read data, valid the cycle after the request |
| wr_byte_valid | output | 1 | A write data byte is forwarded |
| wr_byte_addr | output | ADDR_W | Address of the forwarded byte |
| wr_byte_data | output | 8 | Forwarded write byte |
| stat_wr_valid | output | 1 | A status write byte is forwarded |
| stat_wr_data | output | 8 | Forwarded status byte |
| wr_commit | output | 1 | Valid write frame closed; start programming |
| cmd_wren | output | 1 | Write-enable command completed |
| cmd_wrdi | output | 1 | Write-disable command completed |

## Verification
The hardest state to reach from the ports is a pause held in the middle of an output byte. The output must freeze at the exact bit, ignore clock pulses and input toggles while held, and resume so that the byte and the next prefetched byte both come out intact. The bench drives the serial lines bit by bit. It asserts the pause after three data bits with the serial clock low, toggles the clock and input while paused, releases the pause and completes two bytes. The busy refusal is reached by raising the busy input before the opcode's last bit, both for a refused write and for a status read that must still answer.

// File: rtl/spi_front_pkg.sv
// Shared definitions for the serial memory front-end: frame phases and opcodes.
package spi_front_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,    // chip select high
        ST_OPC,     // collecting opcode
        ST_ADDR,    // collecting two address bytes
        ST_RDATA,   // streaming array data
        ST_WDATA,   // collecting write data
        ST_SRD,     // streaming status byte
        ST_SWR,     // collecting status write byte
        ST_WEN,     // write-enable opcode taken
        ST_WDI,     // write-disable opcode taken
        ST_DROP     // frame ignored until chip select rises
    } fe_state_t;

    localparam logic [7:0] OPC_SET_WE   = 8'h06;
    localparam logic [7:0] OPC_CLR_WE   = 8'h04;
    localparam logic [7:0] OPC_STAT_RD  = 8'h05;
    localparam logic [7:0] OPC_STAT_WR  = 8'h01;
    localparam logic [7:0] OPC_DATA_RD  = 8'h03;
    localparam logic [7:0] OPC_DATA_WR  = 8'h02;

endpackage

// File: rtl/spi_sync.sv
// Multi-bit two-flop synchronizer. Each bit is an independent asynchronous
// level. Assumes no bit needs coherence with any other. RST_VAL gives the
// idle level of each line.
module spi_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two-stage capture of one asynchronous line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1[i] <= RST_VAL[i];
                q_sync[i] <= RST_VAL[i];
            end else begin
                stage1[i] <= d_async[i];
                q_sync[i] <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/spi_link.sv
// Serial link conditioning. Turns the synchronized clock and select into
// single-cycle edge strobes and tracks the pause state. The pause state may
// only change while the serial clock is low. Assumes inputs are already
// synchronized.
module spi_link (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cs_n_s,
    input  logic hold_n_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_start,
    output logic cs_end,
    output logic held,
    output logic cs_active
);
    logic sck_q;
    logic cs_q;

    // Previous values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_s;
            cs_q  <= cs_n_s;
        end
    end

    // Pause follows the hold line only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= 1'b0;
        else if (cs_n_s)
            held <= 1'b0;
        else if (!sck_s)
            held <= !hold_n_s;
    end

    assign cs_active = !cs_n_s;
    assign cs_start  = cs_q && !cs_n_s;
    assign cs_end    = !cs_q && cs_n_s;
    assign sck_rise  = sck_s && !sck_q && !held && !cs_n_s;
    assign sck_fall  = !sck_s && sck_q && !held && !cs_n_s;

    // Pause may only be entered or left while the serial clock is low (R11).
    assert_hold_low_clock_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && $past(!cs_n_s) && held != $past(held)) |-> !$past(sck_s));
endmodule

// File: rtl/spi_cmd_ctrl.sv
// Frame controller. Collects the opcode and address and decides the frame's
// phase. Forwards write and status bytes, issues array fetches for reads and
// emits command pulses when chip select rises. Assumes at most one strobe
// per cycle among the edge inputs, which holds when each serial clock
// half-period is at least four system clocks.
module spi_cmd_ctrl
    import spi_front_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PAGE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              busy,
    output logic              load_slot,
    output logic              sel_status,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              st_wr_valid,
    output logic [7:0]        st_wr_data,
    output logic              wr_commit,
    output logic              wren_p,
    output logic              wrdi_p
);
    localparam int HI_W = ADDR_W - 8;

    fe_state_t         state;
    logic [2:0]        bit_cnt;
    logic [6:0]        sh;
    logic [HI_W-1:0]   addr_hi;
    logic              addr_second;
    logic              is_read;
    logic              wrote;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        in_byte;
    logic              byte_done;
    logic [ADDR_W-1:0] new_addr;

    assign in_byte    = {sh, mosi_s};
    assign byte_done  = sck_rise && (bit_cnt == 3'd7);
    assign new_addr   = {addr_hi, in_byte};
    assign load_slot  = (state == ST_RDATA || state == ST_SRD) && (bit_cnt == 3'd0);
    assign sel_status = (state == ST_SRD);

    // Frame sequencing, byte forwarding and command pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            sh          <= '0;
            addr_hi     <= '0;
            addr_second <= 1'b0;
            is_read     <= 1'b0;
            wrote       <= 1'b0;
            cur_addr    <= '0;
            ptr         <= '0;
            rd_en       <= 1'b0;
            rd_addr     <= '0;
            wr_valid    <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            st_wr_valid <= 1'b0;
            st_wr_data  <= '0;
            wr_commit   <= 1'b0;
            wren_p      <= 1'b0;
            wrdi_p      <= 1'b0;
        end else begin
            rd_en       <= 1'b0;
            wr_valid    <= 1'b0;
            st_wr_valid <= 1'b0;
            wr_commit   <= 1'b0;
            wren_p      <= 1'b0;
            wrdi_p      <= 1'b0;
            if (cs_end) begin
                if ((state == ST_WDATA || state == ST_SWR) && wrote && bit_cnt == 3'd0)
                    wr_commit <= 1'b1;
                if (state == ST_WEN && bit_cnt == 3'd0)
                    wren_p <= 1'b1;
                if (state == ST_WDI && bit_cnt == 3'd0)
                    wrdi_p <= 1'b1;
                state <= ST_IDLE;
            end else if (cs_start) begin
                state       <= ST_OPC;
                bit_cnt     <= '0;
                addr_second <= 1'b0;
                wrote       <= 1'b0;
            end else begin
                if (sck_rise && state != ST_IDLE) begin
                    sh      <= in_byte[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                end
                if (byte_done) begin
                    case (state)
                        ST_OPC: begin
                            if (busy && in_byte != OPC_STAT_RD)
                                state <= ST_DROP;
                            else begin
                                case (in_byte)
                                    OPC_SET_WE:  state <= ST_WEN;
                                    OPC_CLR_WE:  state <= ST_WDI;
                                    OPC_STAT_RD: state <= ST_SRD;
                                    OPC_STAT_WR: state <= ST_SWR;
                                    OPC_DATA_RD: begin state <= ST_ADDR; is_read <= 1'b1; end
                                    OPC_DATA_WR: begin state <= ST_ADDR; is_read <= 1'b0; end
                                    default:     state <= ST_DROP;
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            if (!addr_second) begin
                                addr_hi     <= in_byte[HI_W-1:0];
                                addr_second <= 1'b1;
                            end else begin
                                cur_addr <= new_addr;
                                if (is_read) begin
                                    state   <= ST_RDATA;
                                    rd_en   <= 1'b1;
                                    rd_addr <= new_addr;
                                    ptr     <= new_addr + 1'b1;
                                end else begin
                                    state <= ST_WDATA;
                                end
                            end
                        end
                        ST_WDATA: begin
                            wr_valid <= 1'b1;
                            wr_addr  <= cur_addr;
                            wr_data  <= in_byte;
                            wrote    <= 1'b1;
                            cur_addr <= {cur_addr[ADDR_W-1:PAGE_BITS],
                                         cur_addr[PAGE_BITS-1:0] + 1'b1};
                        end
                        ST_SWR: begin
                            if (!wrote) begin
                                st_wr_valid <= 1'b1;
                                st_wr_data  <= in_byte;
                                wrote       <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (sck_fall && state == ST_RDATA && bit_cnt == 3'd0) begin
                    rd_en   <= 1'b1;
                    rd_addr <= ptr;
                    ptr     <= ptr + 1'b1;
                end
            end
        end
    end

    // A refused opcode while busy leads to the ignore phase (R9).
    assert_busy_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && state == ST_OPC && busy && in_byte != OPC_STAT_RD && !cs_end && !cs_start)
        |=> state == ST_DROP);
    // An ignored frame produces no activity (R10).
    assert_drop_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |=> (!wr_valid && !st_wr_valid && !rd_en && !wr_commit));
    // Commit only on the cycle after chip select rises (R6).
    assert_commit_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(cs_end));
    // Array fetches are isolated single-cycle requests (R4).
    assert_fetch_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
endmodule

// File: rtl/spi_tx.sv
// Output shifter. Captures array data one cycle after each fetch. Loads a
// new byte at the first falling edge of each output byte and otherwise
// shifts most significant bit first. Drives the pad enable only while
// selected, loaded and not paused.
module spi_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_fall,
    input  logic       load_slot,
    input  logic       sel_status,
    input  logic [7:0] status_byte,
    input  logic       rd_en,
    input  logic [7:0] arr_rd_data,
    input  logic       cs_active,
    input  logic       held,
    output logic       miso,
    output logic       miso_oe
);
    logic       rd_en_q;
    logic [7:0] fetch_q;
    logic [7:0] shreg;
    logic       live;
    logic [7:0] src;

    assign src = sel_status ? status_byte : fetch_q;

    // Capture returned array data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en_q <= 1'b0;
            fetch_q <= '0;
        end else begin
            rd_en_q <= rd_en;
            if (rd_en_q)
                fetch_q <= arr_rd_data;
        end
    end

    // Load or shift the output byte on serial clock falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            miso  <= 1'b0;
            live  <= 1'b0;
        end else if (!cs_active) begin
            live <= 1'b0;
        end else if (sck_fall && load_slot) begin
            shreg <= {src[6:0], 1'b0};
            miso  <= src[7];
            live  <= 1'b1;
        end else if (sck_fall && live) begin
            miso  <= shreg[7];
            shreg <= {shreg[6:0], 1'b0};
        end
    end

    assign miso_oe = live && cs_active && !held;

    // Bits leave most significant first, one per falling edge (R2).
    assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && live && !load_slot && cs_active) |=> miso == $past(shreg[7]));
endmodule

// File: rtl/spi_mem_front.sv
// Top of the serial memory command front-end. Synchronizes the serial pins,
// conditions the link, runs the frame controller and drives the output
// shifter. Assumes each serial clock half-period lasts at least four system
// clocks.
module spi_mem_front #(
    parameter int ADDR_W    = 13,
    parameter int PAGE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              write_busy,
    input  logic [7:0]        status_byte,
    output logic              arr_rd_en,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [7:0]        arr_rd_data,
    output logic              wr_byte_valid,
    output logic [ADDR_W-1:0] wr_byte_addr,
    output logic [7:0]        wr_byte_data,
    output logic              stat_wr_valid,
    output logic [7:0]        stat_wr_data,
    output logic              wr_commit,
    output logic              cmd_wren,
    output logic              cmd_wrdi
);
    localparam int NSYNC = 4;
    localparam logic [NSYNC-1:0] PIN_IDLE = 4'b1010; // hold_n, mosi, cs_n, sck

    logic [NSYNC-1:0] pins_s;
    logic sck_rise, sck_fall, cs_start, cs_end, held, cs_active;
    logic load_slot, sel_status;

    spi_sync #(.W(NSYNC), .RST_VAL(PIN_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({spi_hold_n, spi_mosi, spi_cs_n, spi_sck}),
        .q_sync  (pins_s)
    );

    spi_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[0]),
        .cs_n_s    (pins_s[1]),
        .hold_n_s  (pins_s[3]),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .held      (held),
        .cs_active (cs_active)
    );

    spi_cmd_ctrl #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_start    (cs_start),
        .cs_end      (cs_end),
        .sck_rise    (sck_rise),
        .sck_fall    (sck_fall),
        .mosi_s      (pins_s[2]),
        .busy        (write_busy),
        .load_slot   (load_slot),
        .sel_status  (sel_status),
        .rd_en       (arr_rd_en),
        .rd_addr     (arr_rd_addr),
        .wr_valid    (wr_byte_valid),
        .wr_addr     (wr_byte_addr),
        .wr_data     (wr_byte_data),
        .st_wr_valid (stat_wr_valid),
        .st_wr_data  (stat_wr_data),
        .wr_commit   (wr_commit),
        .wren_p      (cmd_wren),
        .wrdi_p      (cmd_wrdi)
    );

    spi_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sck_fall    (sck_fall),
        .load_slot   (load_slot),
        .sel_status  (sel_status),
        .status_byte (status_byte),
        .rd_en       (arr_rd_en),
        .arr_rd_data (arr_rd_data),
        .cs_active   (cs_active),
        .held        (held),
        .miso        (spi_miso),
        .miso_oe     (spi_miso_oe)
    );

    // The pad is never driven while chip select is high at the pins' synced view (R2).
    assert_release_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_s[1] && $past(pins_s[1])) |-> !spi_miso_oe);
endmodule

// File: tb/spi_mem_front_test.sv
// Self-checking bench: a vector table of read-type frames, then directed tests.
module spi_mem_front_test;
    localparam int AW = 13;
    localparam int HP = 8;          // system clocks per serial half-period
    localparam int NV = 7;
    // {opcode[27:20], address[19:4], busy[3], byte count[2:0]}
    localparam logic [27:0] VECS [NV] = '{
        {8'h03, 16'h0000, 1'b0, 3'd2},
        {8'h03, 16'hE123, 1'b0, 3'd3},
        {8'h05, 16'h0000, 1'b0, 3'd2},
        {8'h05, 16'h0000, 1'b1, 3'd1},
        {8'h03, 16'h0040, 1'b1, 3'd1},
        {8'hA5, 16'h0000, 1'b0, 3'd1},
        {8'h03, 16'h1FFF, 1'b0, 3'd2}
    };

    logic clk = 1'b0;
    logic rst_n, cs_n, sck, mosi, hold_n, busy;
    logic [7:0] stat;
    logic miso, miso_oe, arr_rd_en, wr_byte_valid, stat_wr_valid, wr_commit, cmd_wren, cmd_wrdi;
    logic [AW-1:0] arr_rd_addr, wr_byte_addr;
    logic [7:0] arr_rd_data, wr_byte_data, stat_wr_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int wr_cnt = 0, st_cnt = 0, cm_cnt = 0, we_cnt = 0, wd_cnt = 0, rd_cnt = 0;
    logic [AW-1:0] wr_log_a [16];
    logic [7:0] wr_log_d [16];
    logic [7:0] st_last;

    always #5 clk = ~clk;

    spi_mem_front #(.ADDR_W(AW), .PAGE_BITS(6)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .write_busy(busy),
        .status_byte(stat), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
        .arr_rd_data(arr_rd_data), .wr_byte_valid(wr_byte_valid), .wr_byte_addr(wr_byte_addr),
        .wr_byte_data(wr_byte_data), .stat_wr_valid(stat_wr_valid), .stat_wr_data(stat_wr_data),
        .wr_commit(wr_commit), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {a[12:8], 3'b101} ^ 8'h5A;
    endfunction

    // Array model: synchronous read, data one cycle after the request.
    always @(posedge clk) if (arr_rd_en) arr_rd_data <= pat(arr_rd_addr);

    // Output pulse recorder and watchdog.
    always @(posedge clk) begin
        cyc++;
        if (wr_byte_valid) begin
            wr_log_a[wr_cnt % 16] = wr_byte_addr;
            wr_log_d[wr_cnt % 16] = wr_byte_data;
            wr_cnt++;
        end
        if (stat_wr_valid) begin st_last = stat_wr_data; st_cnt++; end
        if (wr_commit) cm_cnt++;
        if (cmd_wren) we_cnt++;
        if (cmd_wrdi) wd_cnt++;
        if (arr_rd_en) rd_cnt++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer_bit(input logic b, output logic r, output logic o);
        mosi = b;
        wait_cyc(HP);
        r = miso;
        o = miso_oe;
        sck = 1'b1;
        wait_cyc(HP);
        sck = 1'b0;
    endtask

    task automatic xfer_byte(input logic [7:0] t, output logic [7:0] r, output logic oe_all, output logic oe_any);
        logic rb, ob;
        oe_all = 1'b1; oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(t[i], rb, ob);
            r[i] = rb;
            oe_all &= ob;
            oe_any |= ob;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_cyc(HP);
    endtask

    task automatic desel();
        cs_n = 1'b1;
        wait_cyc(12);
    endtask

    initial begin
        logic [7:0] rx;
        logic oa, on, rb, ob;
        int w0, c0, s0;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; hold_n = 1'b1; busy = 1'b0; stat = 8'hC6;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(10);

        // R1: reset state
        chk("R1 oe after reset", miso_oe, 0);
        chk("R1 pulses after reset", wr_cnt + st_cnt + cm_cnt + we_cnt + wd_cnt + rd_cnt, 0);

        // Vector table: reads, status reads, busy refusal, unknown opcode, wrap
        for (int v = 0; v < NV; v++) begin
            logic [7:0] op;
            logic [15:0] ad;
            logic bz;
            int nb;
            op = VECS[v][27:20]; ad = VECS[v][19:4]; bz = VECS[v][3]; nb = int'(VECS[v][2:0]);
            busy = bz;
            sel();
            xfer_byte(op, rx, oa, on);
            if (op != 8'h05) begin
                xfer_byte(ad[15:8], rx, oa, on);
                xfer_byte(ad[7:0], rx, oa, on);
            end
            for (int k = 0; k < nb; k++) begin
                xfer_byte(8'h00, rx, oa, on);
                if (op == 8'h05) begin
                    chk("R5 R9 status byte", rx, stat);
                    chk("R2 oe during status out", oa, 1);
                end else if (op == 8'h03 && !bz) begin
                    chk("R3 R4 read data", rx, pat(ad[12:0] + AW'(k)));
                    chk("R2 oe during read out", oa, 1);
                end else begin
                    chk("R9 R10 ignored frame oe", on, 0);
                end
            end
            desel();
            busy = 1'b0;
            chk("R2 oe after release", miso_oe, 0);
        end

        // R8: command pulses at release
        sel(); xfer_byte(8'h06, rx, oa, on); desel();
        chk("R8 write enable pulse", we_cnt, 1);
        sel(); xfer_byte(8'h04, rx, oa, on); desel();
        chk("R8 write disable pulse", wd_cnt, 1);

        // R6 R3: page write with wrap, top address bits ignored
        w0 = wr_cnt; c0 = cm_cnt;
        sel();
        xfer_byte(8'h02, rx, oa, on);
        xfer_byte(8'hFF, rx, oa, on);
        xfer_byte(8'h3E, rx, oa, on);
        xfer_byte(8'hA1, rx, oa, on);
        xfer_byte(8'hB2, rx, oa, on);
        xfer_byte(8'hC3, rx, oa, on);
        desel();
        chk("R6 bytes forwarded", wr_cnt - w0, 3);
        chk("R6 addr0", wr_log_a[w0 % 16], 13'h1F3E);
        chk("R6 addr1", wr_log_a[(w0 + 1) % 16], 13'h1F3F);
        chk("R6 page wrap addr2", wr_log_a[(w0 + 2) % 16], 13'h1F00);
        chk("R6 data2", wr_log_d[(w0 + 2) % 16], 8'hC3);
        chk("R6 commit", cm_cnt - c0, 1);

        // R12: release mid-byte drops partial byte and commit
        w0 = wr_cnt; c0 = cm_cnt;
        sel();
        xfer_byte(8'h02, rx, oa, on);
        xfer_byte(8'h00, rx, oa, on);
        xfer_byte(8'h10, rx, oa, on);
        xfer_byte(8'h77, rx, oa, on);
        for (int i = 0; i < 3; i++) xfer_bit(1'b1, rb, ob);
        desel();
        chk("R12 only whole byte forwarded", wr_cnt - w0, 1);
        chk("R12 no commit", cm_cnt - c0, 0);

        // R7: status write, second byte ignored
        s0 = st_cnt; c0 = cm_cnt;
        sel();
        xfer_byte(8'h01, rx, oa, on);
        xfer_byte(8'h8C, rx, oa, on);
        xfer_byte(8'h55, rx, oa, on);
        desel();
        chk("R7 one status write", st_cnt - s0, 1);
        chk("R7 status data", st_last, 8'h8C);
        chk("R7 commit", cm_cnt - c0, 1);

        // R9: data write refused while busy
        w0 = wr_cnt; c0 = cm_cnt;
        busy = 1'b1;
        sel();
        xfer_byte(8'h02, rx, oa, on);
        xfer_byte(8'h00, rx, oa, on);
        xfer_byte(8'h00, rx, oa, on);
        xfer_byte(8'h99, rx, oa, on);
        desel();
        busy = 1'b0;
        chk("R9 busy write forwarded", wr_cnt - w0, 0);
        chk("R9 busy write commit", cm_cnt - c0, 0);

        // R11: pause in the middle of an output byte
        sel();
        xfer_byte(8'h03, rx, oa, on);
        xfer_byte(8'h00, rx, oa, on);
        xfer_byte(8'h40, rx, oa, on);
        for (int i = 7; i >= 5; i--) begin xfer_bit(1'b0, rb, ob); rx[i] = rb; end
        wait_cyc(4);
        hold_n = 1'b0;
        wait_cyc(6);
        chk("R11 oe low while paused", miso_oe, 0);
        for (int i = 0; i < 2; i++) begin
            mosi = ~mosi; sck = 1'b1; wait_cyc(HP); sck = 1'b0; wait_cyc(HP);
        end
        hold_n = 1'b1;
        wait_cyc(6);
        for (int i = 4; i >= 0; i--) begin xfer_bit(1'b0, rb, ob); rx[i] = rb; end
        chk("R11 byte resumes intact", rx, pat(13'h0040));
        xfer_byte(8'h00, rx, oa, on);
        chk("R11 R4 next byte after pause", rx, pat(13'h0041));
        desel();

        // R12: frame after a completed one needs a new select edge
        sel(); xfer_byte(8'h05, rx, oa, on); xfer_byte(8'h00, rx, oa, on); desel();
        chk("R12 R5 fresh frame status", rx, stat);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule